// File: doc/BRIEF.md
# Matrix Keypad Scanner

The scanner walks a keyboard matrix of up to sixteen rows by eight columns. It raises one row line at a time and reads the column lines at the end of that row's time slot. Every key found during a full sweep becomes a one-byte entry. At the end of the sweep the eight-entry buffer is replaced as a whole by these entries, and a pending count says how many bytes are valid. A host reaches the block through a simple word-addressed register port. Through it the host sets the enable, the per-row debounce extension, the entry-count threshold and the two interrupt enables. It also reads the status and the packed entries, and programs a per-row mask that keeps chosen keys from raising the keypress status.

A sweep begins with a fixed number of idle cycles in which no row is driven. Each row then gets a slot whose length is a fixed base plus the programmed debounce. Turning the enable off stops the sweep at once and throws away any entries gathered in the unfinished sweep.

Register addresses: 0 control, 1 status, 2 low entry word, 3 high entry word, 16+r mask of row r. Control fields: bit 0 enable, bit 1 keypress interrupt enable, bit 3 count interrupt enable, bits 13:4 debounce, bits 17:14 threshold. Status fields: bit 0 keypress, bit 2 count reached, bits 7:4 pending count.

Top module: `kpad_scan`

## Requirements
- R1: While control bit 0 is clear no row is driven and scanning stops; while it is set, sweeps repeat without pause.
- R2: At most one row line is high at any time, and within a sweep the rows are driven in ascending order 0 to NUM_ROWS-1.
- R3: Each row is driven for SCAN_BASE plus debounce (control bits 13:4) cycles. Exactly SWEEP_GAP idle cycles with no row driven come before each sweep.
- R4: An entry byte holds the valid flag in bit 7, the row in bits 6:3 and the column in bits 2:0. Entries follow row-major order (row ascending, then column ascending). Entry k sits in byte k%4 of the low word (address 2) for k<4 and of the high word (address 3) otherwise. Unused bytes read zero.
- R5: A sweep keeps at most eight entries and drops later keys. The pending count (status bits 7:4) equals the number of entries kept in the last sweep.
- R6: At sweep end, status bit 2 sets when the pending count is nonzero and not below the threshold (control bits 17:14). irq goes high while bit 2 and control bit 3 are both set.
- R7: Status bit 0 sets when a sampled pressed key has a clear bit in its row mask (address 16+row, bit = column). A set mask bit suppresses it. irq goes high while bit 0 and control bit 1 are both set.
- R8: Writing 1 to status bit 0 or bit 2 clears that bit; writing 0 leaves it.
- R9: A read strobe (regRe) at address 3 clears the pending count and leaves the entry words unchanged.
- R10: The control register reads back its written fields with all other bits zero. The debounce field is ten bits wide, so it never exceeds 0x3FF. After reset, all registers read zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (side effect at address 3) |
| regAddr | input | 5 | Word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| colSense | input | NUM_COLS | Column lines, high = key pressed on the driven row |
| rowDrive | output | NUM_ROWS | Row lines, one-hot when a row is driven |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the scanner with four rows and four columns and keeps the base slot and gap at their default values. A sweep is then short enough to present every single-key position, the empty and full matrices and about two hundred mixed patterns, each checked byte by byte. The 4×4 matrix has sixteen keys, twice the buffer depth, so the eight-entry cap and the dropping order of late keys are reached often. Row slot lengths are measured at a nonzero debounce.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
  localparam int ENTRY_SLOTS = 8;
  localparam int ENTRY_W     = 8;
  localparam int ROW_FIELD   = 4;
  localparam int COL_FIELD   = 3;
  localparam int DEB_W       = 10;
  localparam int THR_W       = 4;
  localparam int CNT_W       = 4;
  localparam int ADDR_W      = 5;

  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 5'd0;
  localparam logic [ADDR_W-1:0] ADDR_STATUS   = 5'd1;
  localparam logic [ADDR_W-1:0] ADDR_ENTRY_LO = 5'd2;
  localparam logic [ADDR_W-1:0] ADDR_ENTRY_HI = 5'd3;

  // Strobes from the sweep sequencer to the datapath.
  typedef struct packed {
    logic                 sample;
    logic                 sweepEnd;
    logic [ROW_FIELD-1:0] row;
  } scanStrobe_t;
endpackage

// File: rtl/kpad_ctrl.sv
module kpad_ctrl
  import kpad_pkg::*;
#(
  parameter int NUM_ROWS  = 16,
  parameter int SCAN_BASE = 16,
  parameter int SWEEP_GAP = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [DEB_W-1:0]     debounce,
  output scanStrobe_t          strb,
  output logic [NUM_ROWS-1:0]  rowDrive
);
  localparam int TIMER_W = $clog2(SCAN_BASE + (1 << DEB_W) + SWEEP_GAP + 1);
  localparam logic [ROW_FIELD-1:0] LAST_ROW = ROW_FIELD'(NUM_ROWS - 1);
  localparam logic [TIMER_W-1:0]   GAP_LAST = TIMER_W'(SWEEP_GAP - 1);

  typedef enum logic {PH_GAP, PH_ROW} phase_t;

  phase_t               phase;
  logic [TIMER_W-1:0]   timer;
  logic [ROW_FIELD-1:0] rowIdx;
  logic [TIMER_W-1:0]   slotLast;
  logic                 lastTick;

  always_comb begin
    slotLast      = TIMER_W'(SCAN_BASE) + TIMER_W'(debounce) - TIMER_W'(1);
    lastTick      = (phase == PH_ROW) && (timer >= slotLast);
    strb.sample   = lastTick;
    strb.sweepEnd = lastTick && (rowIdx == LAST_ROW);
    strb.row      = rowIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_GAP;
      timer  <= '0;
      rowIdx <= '0;
    end else if (!enable) begin
      phase  <= PH_GAP;
      timer  <= '0;
      rowIdx <= '0;
    end else begin
      unique case (phase)
        PH_GAP: begin
          if (timer == GAP_LAST) begin
            phase  <= PH_ROW;
            timer  <= '0;
            rowIdx <= '0;
          end else begin
            timer <= timer + TIMER_W'(1);
          end
        end
        PH_ROW: begin
          if (lastTick) begin
            timer <= '0;
            if (rowIdx == LAST_ROW) phase <= PH_GAP;
            else                    rowIdx <= rowIdx + ROW_FIELD'(1);
          end else begin
            timer <= timer + TIMER_W'(1);
          end
        end
        default: phase <= PH_GAP;
      endcase
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_rowDrv
    assign rowDrive[r] = (phase == PH_ROW) && (rowIdx == ROW_FIELD'(r));
  end
endmodule

// File: rtl/kpad_datapath.sv
module kpad_datapath
  import kpad_pkg::*;
#(
  parameter int NUM_ROWS = 16,
  parameter int NUM_COLS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic                 regRe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  scanStrobe_t          strb,
  input  logic [NUM_COLS-1:0]  colSense,
  output logic                 enable,
  output logic [DEB_W-1:0]     debounce,
  output logic [CNT_W-1:0]     pendCount,
  output logic                 irq
);
  localparam int POS_W = $clog2(ENTRY_SLOTS + NUM_COLS + 1);
  localparam logic [POS_W-1:0] SLOTS = POS_W'(ENTRY_SLOTS);

  logic             kpEn, fifoEn;
  logic [THR_W-1:0] thresh;
  logic             kpSt, fifoSt;

  logic [ENTRY_W-1:0]  entryBuf  [ENTRY_SLOTS];
  logic [ENTRY_W-1:0]  stage     [ENTRY_SLOTS];
  logic [ENTRY_W-1:0]  stageNext [ENTRY_SLOTS];
  logic [CNT_W-1:0]    stageCnt, cntNext;
  logic [NUM_COLS-1:0] maskReg   [NUM_ROWS];
  logic [NUM_COLS-1:0] rowMask;
  logic [POS_W-1:0]    pos       [NUM_COLS+1];

  logic wrCtrl, wrStatus, rdClear, kpHit, fifoHit;

  assign wrCtrl   = regWe && (regAddr == ADDR_CTRL);
  assign wrStatus = regWe && (regAddr == ADDR_STATUS);
  assign rdClear  = regRe && (regAddr == ADDR_ENTRY_HI);

  // Running slot index for each pressed column of the sampled row.
  assign pos[0] = POS_W'(stageCnt);
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_pos
    assign pos[c+1] = pos[c] + POS_W'(colSense[c]);
  end

  always_comb begin
    rowMask = '0;
    for (int r = 0; r < NUM_ROWS; r++)
      if (strb.row == ROW_FIELD'(r)) rowMask = maskReg[r];
  end

  always_comb begin
    for (int k = 0; k < ENTRY_SLOTS; k++) stageNext[k] = stage[k];
    for (int c = 0; c < NUM_COLS; c++)
      if (colSense[c] && (pos[c] < SLOTS))
        stageNext[pos[c][2:0]] = {1'b1, strb.row, COL_FIELD'(c)};
    cntNext = (pos[NUM_COLS] > SLOTS) ? CNT_W'(ENTRY_SLOTS) : CNT_W'(pos[NUM_COLS]);
  end

  assign kpHit   = strb.sample && |(colSense & ~rowMask);
  assign fifoHit = strb.sweepEnd && (cntNext != '0) && (cntNext >= CNT_W'(thresh));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      kpEn     <= 1'b0;
      fifoEn   <= 1'b0;
      debounce <= '0;
      thresh   <= '0;
    end else if (wrCtrl) begin
      enable   <= regWdata[0];
      kpEn     <= regWdata[1];
      fifoEn   <= regWdata[3];
      debounce <= regWdata[13:4];
      thresh   <= regWdata[17:14];
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) maskReg[r] <= '0;
      else if (regWe && regAddr == (ADDR_W'(16) + ADDR_W'(r)))
        maskReg[r] <= regWdata[NUM_COLS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kpSt   <= 1'b0;
      fifoSt <= 1'b0;
    end else begin
      kpSt   <= kpHit   | (kpSt   & ~(wrStatus & regWdata[0]));
      fifoSt <= fifoHit | (fifoSt & ~(wrStatus & regWdata[2]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < ENTRY_SLOTS; k++) begin
        stage[k]    <= '0;
        entryBuf[k] <= '0;
      end
      stageCnt  <= '0;
      pendCount <= '0;
    end else begin
      if (!enable || strb.sweepEnd) begin
        for (int k = 0; k < ENTRY_SLOTS; k++) stage[k] <= '0;
        stageCnt <= '0;
      end else if (strb.sample) begin
        for (int k = 0; k < ENTRY_SLOTS; k++) stage[k] <= stageNext[k];
        stageCnt <= cntNext;
      end
      if (strb.sweepEnd) begin
        for (int k = 0; k < ENTRY_SLOTS; k++) entryBuf[k] <= stageNext[k];
        pendCount <= cntNext;
      end else if (rdClear) begin
        pendCount <= '0;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_CTRL)
      regRdata = {14'b0, thresh, debounce, fifoEn, 1'b0, kpEn, enable};
    else if (regAddr == ADDR_STATUS)
      regRdata = {24'b0, pendCount, 1'b0, fifoSt, 1'b0, kpSt};
    else if (regAddr == ADDR_ENTRY_LO)
      regRdata = {entryBuf[3], entryBuf[2], entryBuf[1], entryBuf[0]};
    else if (regAddr == ADDR_ENTRY_HI)
      regRdata = {entryBuf[7], entryBuf[6], entryBuf[5], entryBuf[4]};
    else
      for (int r = 0; r < NUM_ROWS; r++)
        if (regAddr == (ADDR_W'(16) + ADDR_W'(r))) regRdata = 32'(maskReg[r]);
  end

  assign irq = (kpSt & kpEn) | (fifoSt & fifoEn);
endmodule

// File: rtl/kpad_scan.sv
module kpad_scan
  import kpad_pkg::*;
#(
  parameter int NUM_ROWS  = 16,
  parameter int NUM_COLS  = 8,
  parameter int SCAN_BASE = 16,
  parameter int SWEEP_GAP = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic                 regRe,
  input  logic [4:0]           regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic [NUM_COLS-1:0]  colSense,
  output logic [NUM_ROWS-1:0]  rowDrive,
  output logic                 irq
);
  scanStrobe_t      strb;
  logic             scanEn;
  logic [DEB_W-1:0] debounce;
  logic [CNT_W-1:0] pendCount;

  kpad_ctrl #(
    .NUM_ROWS(NUM_ROWS), .SCAN_BASE(SCAN_BASE), .SWEEP_GAP(SWEEP_GAP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(scanEn), .debounce(debounce),
    .strb(strb), .rowDrive(rowDrive)
  );

  kpad_datapath #(
    .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb), .colSense(colSense),
    .enable(scanEn), .debounce(debounce), .pendCount(pendCount), .irq(irq)
  );
endmodule

// File: rtl/kpad_checker.sv
module kpad_checker #(
  parameter int NUM_ROWS = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                enable,
  input logic                sample,
  input logic                sweepEnd,
  input logic [NUM_ROWS-1:0] rowDrive,
  input logic [3:0]          pendCount,
  input logic                regRe,
  input logic [4:0]          regAddr
);
  p_one_row_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowDrive));

  p_idle_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (rowDrive == '0));

  p_hold_row_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !sample && rowDrive != '0) |=> $stable(rowDrive));

  p_end_last_row_r2: assert property (@(posedge clk) disable iff (!rstN)
    sweepEnd |-> rowDrive[NUM_ROWS-1]);

  p_count_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    pendCount <= 4'd8);

  p_count_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount < $past(pendCount)) |-> ($past(regRe && regAddr == 5'd3) || $past(sweepEnd)));
endmodule

bind kpad_scan kpad_checker #(.NUM_ROWS(NUM_ROWS)) u_chk (
  .clk(clk), .rstN(rstN), .enable(scanEn), .sample(strb.sample),
  .sweepEnd(strb.sweepEnd), .rowDrive(rowDrive), .pendCount(pendCount),
  .regRe(regRe), .regAddr(regAddr)
);

// File: tb/kpad_scan_bench.sv
`timescale 1ns/1ps
module kpad_scan_bench;
  localparam int NR = 4;
  localparam int NC = 4;
  localparam int BASE = 16;
  localparam int GAP = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWe = 1'b0, regRe = 1'b0;
  logic [4:0]    regAddr = '0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic [NC-1:0] colSense;
  logic [NR-1:0] rowDrive;
  logic          irq;
  logic [15:0]   pat = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  kpad_scan #(.NUM_ROWS(NR), .NUM_COLS(NC), .SCAN_BASE(BASE), .SWEEP_GAP(GAP)) u_kpad_scan (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .colSense(colSense),
    .rowDrive(rowDrive), .irq(irq)
  );

  // Keyboard model: a pressed key connects its row line to its column line.
  always_comb begin
    colSense = '0;
    for (int r = 0; r < NR; r++)
      if (rowDrive[r]) colSense = colSense | pat[r*NC +: NC];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not finish (actual=%0d cycles expected<150000)", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic rdClear();
    @(negedge clk);
    regAddr = 5'd3; regRe = 1'b1;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic waitSweep();
    @(negedge clk);
    while (!rowDrive[NR-1]) @(negedge clk);
    while (rowDrive != '0) @(negedge clk);
  endtask

  task automatic settle();
    waitSweep();
    waitSweep();
  endtask

  task automatic calcExp(input logic [15:0] p, output logic [31:0] lo,
                         output logic [31:0] hi, output int n);
    logic [63:0] e;
    e = '0;
    n = 0;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        if (p[r*NC + c] && n < 8) begin
          e[n*8 +: 8] = {1'b1, 4'(r), 3'(c)};
          n++;
        end
    lo = e[31:0];
    hi = e[63:32];
  endtask

  task automatic checkPattern(input logic [15:0] p);
    logic [31:0] lo, hi, v;
    int n;
    pat = p;
    settle();
    calcExp(p, lo, hi, n);
    rd(5'd2, v); chk("R4 low word", v, lo);
    rd(5'd3, v); chk("R4 high word", v, hi);
    rd(5'd1, v); chk("R5 pending count", 32'(v[7:4]), 32'(n));
  endtask

  initial begin
    logic [31:0] v, lo0, hi0;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state
    for (int a = 0; a < 4; a++) begin
      rd(5'(a), v); chk("R10 reset register", v, 32'h0);
    end
    chk("R10 reset irq", 32'(irq), 32'h0);

    // R1: no rows while disabled
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rowDrive != '0) n++;
    end
    chk("R1 idle while disabled", 32'(n), 32'h0);

    // R10: control field readback
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd0, v); chk("R10 control readback", v, 32'h0003_FFFB);
    chk("R10 debounce max", 32'(v[13:4]), 32'h3FF);
    wr(5'd0, 32'h0);
    wr(5'd1, 32'h5);
    wr(5'd17, 32'hA5);
    rd(5'd17, v); chk("R10 mask readback", v, 32'h5);
    wr(5'd17, 32'h0);

    // R2, R3: row order and slot lengths with debounce 3
    wr(5'd0, 32'h31);
    @(negedge clk);
    while (rowDrive != '0) @(negedge clk);
    while (rowDrive != 4'b0001) @(negedge clk);
    for (int r = 0; r < NR; r++) begin
      n = 0;
      while (rowDrive == 4'(1 << r)) begin n++; @(negedge clk); end
      chk("R3 row slot length", 32'(n), 32'(BASE + 3));
      if (r < NR - 1) chk("R2 next row ascending", 32'(rowDrive), 32'(1 << (r + 1)));
    end
    n = 0;
    while (rowDrive == '0) begin n++; @(negedge clk); end
    chk("R3 sweep gap", 32'(n), 32'(GAP));
    chk("R1 sweeps repeat", 32'(rowDrive), 32'h1);

    // R4, R5: single keys, empty, full, mixed patterns
    wr(5'd0, 32'h1);
    for (int k = 0; k < 16; k++) checkPattern(16'(1 << k));
    checkPattern(16'h0000);
    checkPattern(16'hFFFF);
    for (int i = 1; i <= 200; i++) checkPattern(16'((i * 40503) ^ (i << 5)));

    // R9: reading the high word clears the count but not the entries
    pat = 16'h0123;
    settle();
    wr(5'd0, 32'h0);
    calcExp(16'h0123, lo0, hi0, n);
    rd(5'd1, v); chk("R9 count before read", 32'(v[7:4]), 32'(n));
    rdClear();
    rd(5'd1, v); chk("R9 count cleared", 32'(v[7:4]), 32'h0);
    rd(5'd2, v); chk("R9 low word kept", v, lo0);

    // R6: threshold 3, count interrupt enabled
    wr(5'd1, 32'h5);
    pat = 16'h0011;
    wr(5'd0, 32'h1 | 32'h8 | (32'd3 << 14));
    settle();
    rd(5'd1, v); chk("R6 below threshold status", 32'(v[2]), 32'h0);
    chk("R6 below threshold irq", 32'(irq), 32'h0);
    pat = 16'h0111;
    settle();
    rd(5'd1, v); chk("R6 at threshold status", 32'(v[2]), 32'h1);
    chk("R6 at threshold irq", 32'(irq), 32'h1);

    // R8: write-one clears while scanning is stopped
    wr(5'd0, 32'h8 | (32'd3 << 14));
    wr(5'd1, 32'h0);
    rd(5'd1, v); chk("R8 write zero keeps", 32'(v[2]), 32'h1);
    wr(5'd1, 32'h5);
    rd(5'd1, v); chk("R8 write one clears", 32'(v[2:0]), 32'h0);
    chk("R8 irq after clear", 32'(irq), 32'h0);

    // R6: zero threshold with no keys does not set
    pat = 16'h0000;
    wr(5'd0, 32'h9);
    settle();
    rd(5'd1, v); chk("R6 empty sweep no status", 32'(v[2]), 32'h0);

    // R7: mask suppresses keypress status
    wr(5'd0, 32'h0);
    wr(5'd1, 32'h5);
    wr(5'd17, 32'hF);
    pat = 16'h0040;
    wr(5'd0, 32'h3);
    settle();
    rd(5'd1, v); chk("R7 masked key no status", 32'(v[0]), 32'h0);
    chk("R7 masked key no irq", 32'(irq), 32'h0);
    rd(5'd2, v); chk("R7 masked key still reported", v, 32'h0000_008A);
    wr(5'd17, 32'h0);
    waitSweep();
    rd(5'd1, v); chk("R7 unmasked key status", 32'(v[0]), 32'h1);
    chk("R7 unmasked key irq", 32'(irq), 32'h1);

    // R1: disabling stops scanning
    wr(5'd0, 32'h0);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rowDrive != '0) n++;
    end
    chk("R1 stopped after disable", 32'(n), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule